// File: doc/BRIEF.md
# Bit Counting and Byte Comparison Unit

A 64-bit bit-manipulation unit with one registered result stage. Each accepted request carries one or two 64-bit operands, a four-bit operation code and a record flag. The unit returns a 64-bit result one clock later, together with a valid strobe.

The operations cover four groups:

- leading-zero and trailing-zero counts, over the low 32 bits or over all 64 bits;
- set-bit population counts, per byte, per 32-bit half or over the whole doubleword;
- parity of the byte least-significant bits, per 32-bit half or over the whole doubleword;
- a bytewise equality mask.

When the record flag is set, a three-bit condition output reports whether the result, read as a signed 64-bit number, is below, above or equal to zero.

Bytes are numbered from the least significant end: byte k occupies bits 8k+7..8k. The low half is bits 31..0 and the high half is bits 63..32.

Top module: `bitcount_unit`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0, `result` is 0 and `cond` is 0, until the first accepted request.
- R2: A request with `in_valid` high appears on `result` and `cond` with `out_valid` high on the next clock edge. In a cycle with `in_valid` low, `out_valid` goes low at the next edge and `result` and `cond` keep their values.
- R3: Op 9 (byte compare) sets result byte k to 0xFF when byte k of `opa` equals byte k of `opb`, and to 0x00 otherwise, for all 8 bytes.
- R4: Op 4 (byte popcount) places the number of set bits of byte k of `opa` into byte k of the result.
- R5: Op 5 (half popcount) places the set-bit count of `opa[31:0]` in `result[31:0]` and that of `opa[63:32]` in `result[63:32]`. Op 6 (full popcount) returns the set-bit count of all 64 bits.
- R6: Op 8 (full parity) puts into `result[0]` the XOR of bit 0 of all 8 bytes of `opa`. All other result bits are 0.
- R7: Op 7 (half parity) puts the XOR of bit 0 of bytes 0..3 in `result[0]` and the XOR of bit 0 of bytes 4..7 in `result[32]`. All other result bits are 0.
- R8: Op 2 counts the zero bits of `opa[31:0]` below its lowest set bit, giving 32 for an all-zero low word. Op 3 does the same over all 64 bits, giving 64 for zero.
- R9: Op 0 counts the zero bits of `opa[31:0]` above its highest set bit, giving 32 for an all-zero low word. Op 1 does the same over all 64 bits, giving 64 for zero.
- R10: With `rec` high, `cond` is {lt, gt, eq} (bit 2 = lt, bit 1 = gt, bit 0 = eq) from a signed compare of the result with zero. With `rec` low, `cond` is 0.
- R11: Op codes 10 to 15 return a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| rec | input | 1 | Record flag: produce the condition output |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand (byte compare only) |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Registered result |
| cond | output | 3 | {lt, gt, eq} against zero, or 0 |

## Verification
The assertions check the following on every cycle:

- the one-cycle handshake and the hold of the result in idle cycles;
- that the condition code is one-hot when recorded and zero otherwise;
- the shape of each result class: counts never above 64, byte-popcount bytes never above 8, parity results confined to bits 0 and 32, and compare bytes only 0x00 or 0xFF.

The actual count values, the parity of chosen byte patterns, the lane placement and the 32/64 all-zero limits can only be shown by the bench's vectors with known answers.

// File: rtl/bitcount_unit.sv
module bitcount_unit #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   op,
  input  logic         rec,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic [2:0]   cond
);
  localparam int H  = W / 2;
  localparam int NB = W / 8;
  localparam int CW = $clog2(W) + 1;

  localparam logic [3:0] OP_LZW = 4'd0, OP_LZD = 4'd1, OP_TZW = 4'd2, OP_TZD = 4'd3,
                         OP_PCB = 4'd4, OP_PCW = 4'd5, OP_PCD = 4'd6, OP_PRW = 4'd7,
                         OP_PRD = 4'd8, OP_CMB = 4'd9;

  logic [CW-1:0] lzw, lzd, tzw, tzd;
  logic [W-1:0]  pcb, cmb, nxt;
  logic          par_lo, par_hi;
  logic [3:0]    op_q;
  logic          rec_q;

  always_comb begin
    lzw = CW'(H);
    lzd = CW'(W);
    for (int i = 0; i < H; i++) if (opa[i]) lzw = CW'(H - 1 - i);
    for (int i = 0; i < W; i++) if (opa[i]) lzd = CW'(W - 1 - i);
    tzw = CW'(H);
    tzd = CW'(W);
    for (int i = H - 1; i >= 0; i--) if (opa[i]) tzw = CW'(i);
    for (int i = W - 1; i >= 0; i--) if (opa[i]) tzd = CW'(i);
  end

  always_comb begin
    par_lo = 1'b0;
    par_hi = 1'b0;
    for (int k = 0; k < NB; k++) begin
      pcb[8*k +: 8] = 8'($countones(opa[8*k +: 8]));
      cmb[8*k +: 8] = (opa[8*k +: 8] == opb[8*k +: 8]) ? 8'hFF : 8'h00;
      if (k < NB / 2) par_lo = par_lo ^ opa[8*k];
      else            par_hi = par_hi ^ opa[8*k];
    end
  end

  always_comb begin
    case (op)
      OP_LZW:  nxt = W'(lzw);
      OP_LZD:  nxt = W'(lzd);
      OP_TZW:  nxt = W'(tzw);
      OP_TZD:  nxt = W'(tzd);
      OP_PCB:  nxt = pcb;
      OP_PCW:  nxt = {H'($countones(opa[W-1:H])), H'($countones(opa[H-1:0]))};
      OP_PCD:  nxt = W'($countones(opa));
      OP_PRW:  nxt = {{(H-1){1'b0}}, par_hi, {(H-1){1'b0}}, par_lo};
      OP_PRD:  nxt = W'(par_lo ^ par_hi);
      OP_CMB:  nxt = cmb;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      cond      <= '0;
      op_q      <= '0;
      rec_q     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt;
        cond   <= rec ? {nxt[W-1], !nxt[W-1] && (nxt != '0), nxt == '0} : 3'b000;
        op_q   <= op;
        rec_q  <= rec;
      end
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(cond));
  p_cond_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && rec_q |-> $countones(cond) == 1);
  p_cond_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !rec_q |-> cond == 3'b000);
  p_count_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (op_q <= OP_TZD || op_q == OP_PCD) |-> result <= W);
  p_parity_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (op_q == OP_PRW || op_q == OP_PRD)
      |-> (result & ~(W'(1) | (W'(1) << H))) == '0);
  p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op_q > OP_CMB |-> result == '0);

  for (genvar k = 0; k < NB; k++) begin : g_lane_chk
    p_cmp_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && op_q == OP_CMB |-> result[8*k +: 8] == 8'h00 || result[8*k +: 8] == 8'hFF);
    p_pcb_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && op_q == OP_PCB |-> result[8*k +: 8] <= 8'd8);
  end
endmodule

// File: tb/bitcount_unit_bench.sv
module bitcount_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic        rec = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic        out_valid;
  logic [63:0] result;
  logic [2:0]  cond;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  bitcount_unit u_bitcount_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .rec(rec),
    .opa(opa), .opb(opb), .out_valid(out_valid), .result(result), .cond(cond)
  );

  localparam int NV = 20;
  localparam logic [199:0] VEC [NV] = '{
    {4'd0, 1'b0, 64'hFFFF_FFFF_0000_0001, 64'h0, 64'd31, 3'b000},
    {4'd0, 1'b0, 64'hFFFF_FFFF_0000_0000, 64'h0, 64'd32, 3'b000},
    {4'd1, 1'b0, 64'h0000_0000_0001_0000, 64'h0, 64'd47, 3'b000},
    {4'd1, 1'b1, 64'h0,                   64'h0, 64'd64, 3'b010},
    {4'd2, 1'b0, 64'h0000_0001_0000_0000, 64'h0, 64'd32, 3'b000},
    {4'd2, 1'b0, 64'h0000_0000_0000_0080, 64'h0, 64'd7,  3'b000},
    {4'd3, 1'b0, 64'h8000_0000_0000_0000, 64'h0, 64'd63, 3'b000},
    {4'd3, 1'b0, 64'h0,                   64'h0, 64'd64, 3'b000},
    {4'd4, 1'b0, 64'hFF01_0300_0F7F_8001, 64'h0, 64'h0801_0200_0407_0101, 3'b000},
    {4'd4, 1'b1, 64'h0,                   64'h0, 64'h0, 3'b001},
    {4'd5, 1'b0, 64'hFFFF_FFFF_0000_0007, 64'h0, 64'h0000_0020_0000_0003, 3'b000},
    {4'd6, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'd64, 3'b010},
    {4'd8, 1'b1, 64'h0102_0000_0000_0003, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 3'b001},
    {4'd8, 1'b0, 64'h0001_0000_0000_00FE, 64'h0, 64'h1, 3'b000},
    {4'd7, 1'b0, 64'h0100_0000_0101_0100, 64'h0, 64'h0000_0001_0000_0001, 3'b000},
    {4'd7, 1'b0, 64'h0101_0000_0000_0001, 64'h0, 64'h0000_0000_0000_0001, 3'b000},
    {4'd9, 1'b1, 64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788, 64'hFFFF_00FF_FF00_FFFF, 3'b100},
    {4'd9, 1'b0, 64'hA5A5_A5A5_A5A5_A5A5, 64'h5A5A_5A5A_5A5A_5A5A, 64'h0, 3'b000},
    {4'd12, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 3'b001},
    {4'd9, 1'b1, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 3'b100}
  };

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: return "R9";
      4'd2, 4'd3: return "R8";
      4'd4:       return "R4";
      4'd5, 4'd6: return "R5";
      4'd7:       return "R7";
      4'd8:       return "R6";
      4'd9:       return "R3";
      default:    return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic r, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    op = o; rec = r; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {62'h0, out_valid, 1'b0}, 64'h0);
    check("R1", result, 64'h0);
    check("R1", 64'(cond), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {63'h0, out_valid}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][199:196], VEC[i][195], VEC[i][194:131], VEC[i][130:67]);
      check("R2", 64'(out_valid), 64'h1);
      check(req_of(VEC[i][199:196]), result, VEC[i][66:3]);
      check("R10", 64'(cond), 64'(VEC[i][2:0]));
    end

    // R2: idle cycle with new operands leaves the registered outputs untouched
    @(negedge clk);
    op = 4'd6; opa = 64'h0; rec = 1'b1;
    @(negedge clk);
    check("R2", 64'(out_valid), 64'h0);
    check("R2", result, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R2", 64'(cond), 64'h4);

    // R2: back-to-back requests, each visible one cycle later
    @(negedge clk);
    in_valid = 1'b1; op = 4'd6; rec = 1'b0; opa = 64'h0000_0000_0000_00FF;
    @(negedge clk);
    check("R5", result, 64'd8);
    op = 4'd0; opa = 64'h0000_0000_8000_0000;
    @(negedge clk);
    check("R9", result, 64'd0);
    check("R2", 64'(out_valid), 64'h1);
    in_valid = 1'b0;
    @(negedge clk);
    check("R2", 64'(out_valid), 64'h0);

    // R10: negative result with record flag clear gives zero cond
    issue(4'd9, 1'b0, 64'h0, 64'h0);
    check("R10", 64'(cond), 64'h0);

    // R1: reset mid-stream clears the outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", result, 64'h0);
    check("R1", 64'(out_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    summary();
  end
endmodule